// File: doc/BRIEF.md
# Receive Frame Word Queue

This block is the receive-side buffer of an Ethernet MAC as a host sees it through a 32-bit read port. Received bytes, FCS included, arrive one per clock with an end-of-frame strobe and a status value. The block packs them into 32-bit words in a circular word store. When a frame completes, the block writes two words in front of the payload: a fixed sync word and a word that packs the length and status. Only then does it expose the frame to the reader.

The host checks the frame-count output to see whether anything is pending. It then pops words in order: the sync word, the length/status word, and the payload rounded up to whole words. If the sync word is not the expected constant, the host has lost alignment. It recovers by raising the flush input, which empties the store and reports busy until it is done. A frame that cannot fit in the free space is discarded whole. A frame shorter than 64 bytes is still stored, but it carries a runt flag.

Top module: `rxq_frame_buf`

## Requirements
- R1: After reset, frame_cnt_o is 0, flush_busy_o is 0 and rd_data_o is 0.
- R2: The first word popped for every frame is the sync constant 32'h5AA5_0143.
- R3: The second word popped holds the received byte count, FCS included, in bits 15:0. Bit 16 is 1 when that count is below 64. Bits 31:17 hold rx_status_i as sampled with the last byte.
- R4: Payload follows as ceil(len/4) words. Byte k of the frame sits in word k/4 at bits 8*(k%4)+7 : 8*(k%4). Unused upper bytes of the last word are zero.
- R5: frame_cnt_o rises by one on the clock edge that takes the last byte of an accepted frame. It falls by one on the edge that pops that frame's last payload word.
- R6: A pulse on cnt_clr_i forces frame_cnt_o to 0 without touching stored words. Later decrements stop at 0.
- R7: A one-cycle pulse on flush_i makes flush_busy_o read 1 in the following cycle and 0 after that. It leaves the store empty and frame_cnt_o at 0.
- R8: A frame whose 2+ceil(len/4) words exceed the free space is dropped whole and not counted. Later frames that fit are accepted.
- R9: While the store is empty, rd_data_o is 0 and rd_en_i has no effect.
- R10: Several stored frames are read back in arrival order.
- R11: A frame in progress when a flush takes effect is discarded, including any bytes that arrive after the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_byte_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Marks the final byte of a frame |
| rx_status_i | input | 15 | Frame status, sampled with the last byte |
| rd_en_i | input | 1 | Pop the word on rd_data_o |
| rd_data_o | output | 32 | Word at the head of the store, 0 when empty |
| frame_cnt_o | output | 8 | Number of complete frames pending |
| cnt_clr_i | input | 1 | Force the frame count to zero |
| flush_i | input | 1 | Request a flush |
| flush_busy_o | output | 1 | Flush in progress |

## Verification
A slipped read pointer or a wrongly sized commit shows up at the next frame boundary: the word popped first is no longer the sync constant, or the length/status word does not match the frame that was sent. A payload decode error in the read-side tracker shows up on frame_cnt_o within one pop, because the count falls too early or too late against the last payload word. A wrong decision about free space shows up when a frame that should have been stored is missing from the count, or when a dropped frame reappears as extra words after the frame that follows it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int LEN_W = 16;
  localparam int ST_W = 15;
  localparam logic [31:0] SYNC_WORD = 32'h5AA5_0143;
  localparam int MIN_LEN = 64;

  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_LEN = 2'd1,
    PH_PAY = 2'd2
  } rd_phase_e;
endpackage

// File: rtl/rxq_word_packer.sv
module rxq_word_packer
  import rxq_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                valid_i,
  input  logic [7:0]          byte_i,
  input  logic                last_i,
  input  logic [ST_W-1:0]     status_i,
  input  logic [AW:0]         free_i,
  output logic                we_o,
  output logic [31:0]         wdata_o,
  output logic [AW-1:0]       widx_o,
  output logic                commit_o,
  output logic [AW:0]         total_o,
  output logic [31:0]         lenstat_o
);
  localparam int IDX_W = LEN_W - 2;

  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [31:0]      acc_q, acc_n;
  logic             drop_q;
  logic [1:0]       lane;
  logic [IDX_W-1:0] idx;
  logic [LEN_W:0]   need;
  logic             ovf, ok, word_end, runt;

  assign lane  = cnt_q[1:0];
  assign idx   = cnt_q[LEN_W-1:2];
  assign cnt_n = cnt_q + 1'b1;
  // words needed once this byte's word is stored: sync + lenstat + payload
  assign need  = (LEN_W+1)'(idx) + (LEN_W+1)'(3);
  assign ovf   = need > (LEN_W+1)'(free_i);
  assign ok    = valid_i && !flush_i && !drop_q && !ovf;
  assign word_end = (lane == 2'd3) || last_i;

  always_comb begin
    if (lane == 2'd0) acc_n = {24'h0, byte_i};
    else              acc_n = acc_q | ({24'h0, byte_i} << {lane, 3'b000});
  end

  assign runt      = cnt_n < LEN_W'(MIN_LEN);
  assign we_o      = ok && word_end;
  assign wdata_o   = acc_n;
  assign widx_o    = idx[AW-1:0];
  assign commit_o  = ok && last_i;
  assign total_o   = need[AW:0];
  assign lenstat_o = {status_i, runt, cnt_n};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      drop_q <= 1'b0;
    end else if (flush_i) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      drop_q <= valid_i ? !last_i : (cnt_q != '0);
    end else if (valid_i) begin
      acc_q <= acc_n;
      if (last_i) begin
        cnt_q  <= '0;
        drop_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_n;
        drop_q <= drop_q | ovf;
      end
    end
  end

  a_r8_commit_room: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> ((LEN_W+1)'(total_o) <= (LEN_W+1)'(free_i)));
endmodule

// File: rtl/rxq_pop_tracker.sv
module rxq_pop_tracker
  import rxq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             pop_i,
  input  logic [LEN_W-1:0] len_i,
  output rd_phase_e        phase_o,
  output logic             done_o
);
  rd_phase_e          phase_q;
  logic [LEN_W-2:0]   rem_q;
  logic [LEN_W:0]     rounded;

  assign rounded = {1'b0, len_i} + (LEN_W+1)'(3);
  assign phase_o = phase_q;
  assign done_o  = pop_i && (phase_q == PH_PAY) && (rem_q == (LEN_W-1)'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_HDR;
      rem_q   <= '0;
    end else if (flush_i) begin
      phase_q <= PH_HDR;
      rem_q   <= '0;
    end else if (pop_i) begin
      unique case (phase_q)
        PH_HDR: phase_q <= PH_LEN;
        PH_LEN: begin
          phase_q <= PH_PAY;
          rem_q   <= rounded[LEN_W:2];
        end
        PH_PAY: begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == (LEN_W-1)'(1)) phase_q <= PH_HDR;
        end
        default: phase_q <= PH_HDR;
      endcase
    end
  end

  a_r4_pay_rem_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PAY) |-> (rem_q != '0));
endmodule

// File: rtl/rxq_frame_buf.sv
module rxq_frame_buf
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rx_valid_i,
  input  logic [7:0]      rx_byte_i,
  input  logic            rx_last_i,
  input  logic [ST_W-1:0] rx_status_i,
  input  logic            rd_en_i,
  output logic [31:0]     rd_data_o,
  output logic [CNT_W-1:0] frame_cnt_o,
  input  logic            cnt_clr_i,
  input  logic            flush_i,
  output logic            flush_busy_o
);
  localparam int AW = $clog2(DEPTH);

  logic [31:0]      mem [DEPTH];
  logic [AW-1:0]    cptr_q, rptr_q;
  logic [AW:0]      occ_q, free_w;
  logic [CNT_W-1:0] cnt_q;
  logic             flush_q;
  logic             empty, pop;

  logic             pk_we, pk_commit;
  logic [31:0]      pk_wdata, pk_lenstat;
  logic [AW-1:0]    pk_widx;
  logic [AW:0]      pk_total;
  rd_phase_e        rd_phase;
  logic             frame_done;

  assign free_w = (AW+1)'(DEPTH) - occ_q;
  assign empty  = (occ_q == '0);
  assign pop    = rd_en_i && !empty && !flush_q;

  assign rd_data_o    = empty ? 32'h0 : mem[rptr_q];
  assign frame_cnt_o  = cnt_q;
  assign flush_busy_o = flush_q;

  rxq_word_packer #(.AW(AW)) u_packer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_q),
    .valid_i   (rx_valid_i),
    .byte_i    (rx_byte_i),
    .last_i    (rx_last_i),
    .status_i  (rx_status_i),
    .free_i    (free_w),
    .we_o      (pk_we),
    .wdata_o   (pk_wdata),
    .widx_o    (pk_widx),
    .commit_o  (pk_commit),
    .total_o   (pk_total),
    .lenstat_o (pk_lenstat)
  );

  rxq_pop_tracker u_tracker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_q),
    .pop_i   (pop),
    .len_i   (rd_data_o[LEN_W-1:0]),
    .phase_o (rd_phase),
    .done_o  (frame_done)
  );

  // payload lands past the two reserved words; both are filled at commit
  always_ff @(posedge clk_i) begin
    if (pk_we) mem[cptr_q + AW'(2) + pk_widx] <= pk_wdata;
    if (pk_commit) begin
      mem[cptr_q]          <= SYNC_WORD;
      mem[cptr_q + AW'(1)] <= pk_lenstat;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cptr_q  <= '0;
      rptr_q  <= '0;
      occ_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= flush_i;
      if (flush_q) begin
        cptr_q <= '0;
        rptr_q <= '0;
        occ_q  <= '0;
        cnt_q  <= '0;
      end else begin
        if (pk_commit) cptr_q <= cptr_q + pk_total[AW-1:0];
        if (pop)       rptr_q <= rptr_q + 1'b1;
        occ_q <= occ_q + (pk_commit ? pk_total : '0) - (AW+1)'(pop);
        if (cnt_clr_i)
          cnt_q <= '0;
        else
          cnt_q <= cnt_q + CNT_W'(pk_commit)
                 - CNT_W'(frame_done && (cnt_q != '0));
      end
    end
  end

  a_r8_occ_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= (AW+1)'(DEPTH));

  a_r2_sync_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && rd_phase == PH_HDR) |-> (rd_data_o == SYNC_WORD));

  a_r7_flush_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |=> !frame_done);

  a_r9_empty_no_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !frame_done);
endmodule

// File: tb/rxq_frame_buf_test.sv
module rxq_frame_buf_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_byte_i = '0;
  logic        rx_last_i = 1'b0;
  logic [14:0] rx_status_i = '0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [7:0]  frame_cnt_o;
  logic        cnt_clr_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        flush_busy_o;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] SYNC = 32'h5AA5_0143;
  localparam int NV = 8;
  localparam int          V_LEN  [NV] = '{1, 2, 3, 4, 5, 63, 64, 65};
  localparam logic [14:0] V_ST   [NV] = '{15'h0001, 15'h7FFF, 15'h1234, 15'h0000,
                                          15'h4AAA, 15'h2555, 15'h0F0F, 15'h7000};
  localparam logic [7:0]  V_SEED [NV] = '{8'h10, 8'hF0, 8'h33, 8'h80,
                                          8'h01, 8'hA5, 8'h5A, 8'hFE};

  always #10 clk = ~clk;

  rxq_frame_buf uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_byte_i    (rx_byte_i),
    .rx_last_i    (rx_last_i),
    .rx_status_i  (rx_status_i),
    .rd_en_i      (rd_en_i),
    .rd_data_o    (rd_data_o),
    .frame_cnt_o  (frame_cnt_o),
    .cnt_clr_i    (cnt_clr_i),
    .flush_i      (flush_i),
    .flush_busy_o (flush_busy_o)
  );

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lenstat(int len, logic [14:0] st);
    return {st, (len < 64), 16'(len)};
  endfunction

  function automatic logic [31:0] exp_word(int len, logic [7:0] seed, int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 4; b++)
      if (4*w + b < len) r[8*b +: 8] = seed + 8'(4*w + b);
    return r;
  endfunction

  task automatic send_bytes(int n, int first, logic [7:0] seed, logic [14:0] st, bit end_it);
    for (int k = 0; k < n; k++) begin
      rx_valid_i  = 1'b1;
      rx_byte_i   = seed + 8'(first + k);
      rx_last_i   = end_it && (k == n - 1);
      rx_status_i = st;
      @(negedge clk);
    end
    rx_valid_i = 1'b0;
    rx_last_i  = 1'b0;
  endtask

  task automatic pop_check(string req, logic [31:0] exp);
    check_eq(req, rd_data_o, exp);
    rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic read_frame(int len, logic [14:0] st, logic [7:0] seed);
    pop_check("R2 sync word", SYNC);
    pop_check("R3 length/status", lenstat(len, st));
    for (int w = 0; w < (len + 3) / 4; w++)
      pop_check("R4 payload", exp_word(len, seed, w));
  endtask

  task automatic flush_pulse();
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    check_eq("R7 busy during flush", 32'(flush_busy_o), 32'd1);
    @(negedge clk);
    check_eq("R7 busy cleared", 32'(flush_busy_o), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check_eq("R1 count", 32'(frame_cnt_o), 0);
    check_eq("R1 busy", 32'(flush_busy_o), 0);
    check_eq("R1 data", rd_data_o, 0);

    // R9: pop on empty is ignored
    rd_en_i = 1'b1;
    repeat (2) @(negedge clk);
    rd_en_i = 1'b0;
    check_eq("R9 empty data", rd_data_o, 0);

    // table walk: one frame at a time
    for (int i = 0; i < NV; i++) begin
      send_bytes(V_LEN[i], 0, V_SEED[i], V_ST[i], 1'b1);
      check_eq("R5 count up", 32'(frame_cnt_o), 1);
      read_frame(V_LEN[i], V_ST[i], V_SEED[i]);
      check_eq("R5 count down", 32'(frame_cnt_o), 0);
      check_eq("R9 empty after frame", rd_data_o, 0);
    end

    // R10: back-to-back frames keep order
    send_bytes(5, 0, 8'h20, 15'h0011, 1'b1);
    send_bytes(9, 0, 8'h40, 15'h0022, 1'b1);
    send_bytes(70, 0, 8'h60, 15'h0033, 1'b1);
    check_eq("R10 count three", 32'(frame_cnt_o), 3);
    read_frame(5, 15'h0011, 8'h20);
    check_eq("R5 count after first", 32'(frame_cnt_o), 2);
    read_frame(9, 15'h0022, 8'h40);
    read_frame(70, 15'h0033, 8'h60);
    check_eq("R10 count zero", 32'(frame_cnt_o), 0);

    // R6: clearing the count leaves data; decrement stops at 0
    send_bytes(12, 0, 8'h77, 15'h0101, 1'b1);
    check_eq("R6 pre clear", 32'(frame_cnt_o), 1);
    cnt_clr_i = 1'b1;
    @(negedge clk);
    cnt_clr_i = 1'b0;
    check_eq("R6 cleared", 32'(frame_cnt_o), 0);
    read_frame(12, 15'h0101, 8'h77);
    check_eq("R6 no underflow", 32'(frame_cnt_o), 0);

    // R7: flush with stored frames
    send_bytes(10, 0, 8'h01, 15'h0002, 1'b1);
    send_bytes(20, 0, 8'h02, 15'h0003, 1'b1);
    check_eq("R7 pre flush", 32'(frame_cnt_o), 2);
    flush_pulse();
    check_eq("R7 count zero", 32'(frame_cnt_o), 0);
    check_eq("R7 empty", rd_data_o, 0);
    send_bytes(8, 0, 8'h90, 15'h0404, 1'b1);
    check_eq("R7 post flush count", 32'(frame_cnt_o), 1);
    read_frame(8, 15'h0404, 8'h90);

    // R11: flush in mid-frame discards the rest
    send_bytes(5, 0, 8'h30, 15'h0505, 1'b0);
    flush_pulse();
    send_bytes(5, 5, 8'h30, 15'h0505, 1'b1);
    check_eq("R11 discarded count", 32'(frame_cnt_o), 0);
    check_eq("R11 discarded data", rd_data_o, 0);
    send_bytes(6, 0, 8'hC0, 15'h0606, 1'b1);
    read_frame(6, 15'h0606, 8'hC0);

    // R8: frame too large for free space is dropped whole
    send_bytes(200, 0, 8'h11, 15'h0707, 1'b1);
    check_eq("R8 big fits", 32'(frame_cnt_o), 1);
    send_bytes(100, 0, 8'h22, 15'h0808, 1'b1);
    check_eq("R8 overflow dropped", 32'(frame_cnt_o), 1);
    send_bytes(30, 0, 8'h33, 15'h0909, 1'b1);
    check_eq("R8 later accepted", 32'(frame_cnt_o), 2);
    read_frame(200, 15'h0707, 8'h11);
    read_frame(30, 15'h0909, 8'h33);
    check_eq("R8 drained", 32'(frame_cnt_o), 0);
    check_eq("R9 drained empty", rd_data_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule